// File: doc/BRIEF.md
# Burst memory pattern tester

This block exercises an external word-addressed memory by moving bursts of 32-bit words between a local 256-word reference buffer and the memory, then checking what comes back. The host loads the reference buffer through a small bus window, writes a memory start address and then writes a command word. The command selects one of two operations. A burst write copies a run of buffer words to consecutive memory addresses. A burst read fetches a run of consecutive memory words and compares each one against the matching buffer word.

A single sticky pass flag gathers the outcome of every compare made since the host last asked for it to be reset. This lets software sweep a large memory region as many short bursts and check one flag at the end. The memory side is a word-at-a-time request/grant port with in-order read responses. Exactly one read is outstanding at any time.

Top module: `mt_burst_tester`

## Requirements
- R1: After reset the block is idle, the status word reads busy (bit 0) = 0 and pass (bit 1) = 1, and no memory request is raised.
- R2: The host window decodes three regions. Offset 0 is the command/status register. Offset 1 is the memory start address register, which reads back the value written. Offsets 0x100 + i reach buffer word i. A read strobe returns its data on `host_rdata` one cycle later.
- R3: A command with bit 16 clear is a burst write. It issues (bits 7:0) + 1 write requests to consecutive addresses that begin at the start address. Write k carries buffer word (bits 15:8) + k.
- R4: A command with bit 16 set is a burst read. It issues the same number of read requests at consecutive addresses and waits for each response before the next request. Each response is compared with buffer word (bits 15:8) + k.
- R5: Any compare mismatch clears the pass flag. The flag then stays clear through later commands, including ones whose compares all match.
- R6: A command with bit 17 set restores the pass flag to 1 as it starts, before any of its own compares. A mismatch within that same command still clears the flag.
- R7: Busy reads 1 from the cycle after an accepted command write until the last word completes. A command write made while busy is ignored entirely: it issues no request and changes no stored field.
- R8: The buffer index wraps modulo 256 within a burst, so a burst that starts at index 252 uses words 252..255 and then 0, 1, and so on.
- R9: Command bit 18 (mode flag) is stored when a command is accepted and reads back at bit 18 of the status word.
- R10: Once a memory request is raised, it stays raised with a stable address and direction until the cycle in which grant is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_addr | input | 9 | Host word offset: register index, or buffer index when bit 8 is set |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid the cycle after the read strobe |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | Request direction, 1 = write |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Memory accepts the current request |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |

## Verification
The assertions assume three things about the memory side. Read responses arrive only after a granted read request. There is exactly one response per read. Grant may be withheld for any number of cycles. The memory model in the bench grants three cycles out of four and returns read data two cycles after the grant, which keeps it inside that contract. The checks also assume the host does not rewrite the reference buffer while a burst runs, because that would change the write data in mid-request. The bench loads the buffer only while the block is idle.

// File: rtl/mt_pkg.sv
package mt_pkg;
   // command word field positions
   localparam int CMD_LEN_LSB  = 0;
   localparam int CMD_IDX_LSB  = 8;
   localparam int CMD_RD_BIT   = 16;
   localparam int CMD_CLR_BIT  = 17;
   localparam int CMD_DUAL_BIT = 18;
   // status word bit positions
   localparam int STAT_BUSY_BIT = 0;
   localparam int STAT_PASS_BIT = 1;
   // register indices in the host window
   localparam int REG_CMD  = 0;
   localparam int REG_ADDR = 1;

   typedef enum logic [1:0] {
      ENG_IDLE,
      ENG_ISSUE,
      ENG_WAIT
   } eng_st_t;
endpackage

// File: rtl/mt_buffer.sv
module mt_buffer #(
   parameter int DW    = 32,
   parameter int DEPTH = 256,
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_en,
   input  logic [IW-1:0] rd_idx,
   output logic [DW-1:0] rd_data,
   input  logic [IW-1:0] eng_idx,
   output logic [DW-1:0] eng_data
);
   if ((1 << IW) != DEPTH) begin : g_depth_chk
      $error("mt_buffer: DEPTH must be a power of two");
   end

   logic [DW-1:0] store [DEPTH];
   logic [DW-1:0] rd_q;

   always_ff @(posedge clk) begin
      if (wr_en) store[wr_idx] <= wr_data;
      if (rd_en) rd_q <= store[rd_idx];
   end

   assign rd_data  = rd_q;
   assign eng_data = store[eng_idx];
endmodule

// File: rtl/mt_hostif.sv
module mt_hostif import mt_pkg::*; #(
   parameter int DW  = 32,
   parameter int AW  = 32,
   parameter int IW  = 8,
   parameter int LW  = 8,
   localparam int HAW = IW + 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [HAW-1:0] host_addr,
   input  logic           host_wr,
   input  logic           host_rd,
   input  logic [DW-1:0]  host_wdata,
   output logic [DW-1:0]  host_rdata,
   input  logic           busy,
   input  logic           pass,
   output logic           start,
   output logic [LW-1:0]  cmd_len_m1,
   output logic [IW-1:0]  cmd_idx,
   output logic           cmd_rd,
   output logic           cmd_clr,
   output logic [AW-1:0]  base_addr,
   output logic           buf_wr,
   output logic           buf_rd,
   output logic [IW-1:0]  buf_idx,
   input  logic [DW-1:0]  buf_rdata
);
   if (DW <= CMD_DUAL_BIT + 1 || IW > 8 || LW > 8) begin : g_map_chk
      $error("mt_hostif: field widths do not fit the command word");
   end

   logic          is_buf;
   logic [IW-1:0] sel;
   logic          cmd_wr, addr_wr;
   logic [AW-1:0] addr_q;
   logic          dual_q;
   logic          rd_buf_q;
   logic [DW-1:0] reg_q;
   logic [DW-1:0] stat;
   logic          unused_hi;

   assign is_buf  = host_addr[HAW-1];
   assign sel     = host_addr[IW-1:0];
   assign cmd_wr  = host_wr && !is_buf && (sel == IW'(REG_CMD));
   assign addr_wr = host_wr && !is_buf && (sel == IW'(REG_ADDR));
   assign start   = cmd_wr && !busy;

   assign cmd_len_m1 = host_wdata[CMD_LEN_LSB +: LW];
   assign cmd_idx    = host_wdata[CMD_IDX_LSB +: IW];
   assign cmd_rd     = host_wdata[CMD_RD_BIT];
   assign cmd_clr    = host_wdata[CMD_CLR_BIT];
   assign base_addr  = addr_q;
   assign unused_hi  = ^host_wdata[DW-1:CMD_DUAL_BIT+1];

   assign buf_wr  = host_wr && is_buf;
   assign buf_rd  = host_rd && is_buf;
   assign buf_idx = sel;

   always_comb begin
      stat = '0;
      stat[STAT_BUSY_BIT] = busy;
      stat[STAT_PASS_BIT] = pass;
      stat[CMD_DUAL_BIT]  = dual_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q   <= '0;
         dual_q   <= 1'b0;
         rd_buf_q <= 1'b0;
         reg_q    <= '0;
      end else begin
         if (addr_wr) addr_q <= host_wdata[AW-1:0];
         if (start)   dual_q <= host_wdata[CMD_DUAL_BIT];
         if (host_rd) begin
            rd_buf_q <= is_buf;
            if (sel == IW'(REG_ADDR)) reg_q <= DW'(addr_q);
            else                      reg_q <= stat;
         end
      end
   end

   assign host_rdata = rd_buf_q ? buf_rdata : reg_q;

   // R7
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && busy) |=> $stable(dual_q));
endmodule

// File: rtl/mt_engine.sv
module mt_engine import mt_pkg::*; #(
   parameter int DW = 32,
   parameter int AW = 32,
   parameter int IW = 8,
   parameter int LW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [LW-1:0] len_m1,
   input  logic [IW-1:0] start_idx,
   input  logic          rd_cmd,
   input  logic          clr_cmd,
   input  logic [AW-1:0] base_addr,
   output logic [IW-1:0] eng_idx,
   input  logic [DW-1:0] eng_data,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic          mem_gnt,
   input  logic          mem_rvalid,
   input  logic [DW-1:0] mem_rdata,
   output logic          busy,
   output logic          pass
);
   eng_st_t       st;
   logic [LW-1:0] cnt, last;
   logic [IW-1:0] idx;
   logic [AW-1:0] maddr;
   logic          rd_q, pass_q;
   logic          at_last;

   assign at_last = (cnt == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ENG_IDLE;
         cnt    <= '0;
         last   <= '0;
         idx    <= '0;
         maddr  <= '0;
         rd_q   <= 1'b0;
         pass_q <= 1'b1;
      end else begin
         case (st)
            ENG_IDLE: if (start) begin
               st    <= ENG_ISSUE;
               cnt   <= '0;
               last  <= len_m1;
               idx   <= start_idx;
               maddr <= base_addr;
               rd_q  <= rd_cmd;
               if (clr_cmd) pass_q <= 1'b1;
            end
            ENG_ISSUE: if (mem_gnt) begin
               if (rd_q) st <= ENG_WAIT;
               else if (at_last) st <= ENG_IDLE;
               else begin
                  cnt   <= cnt + 1'b1;
                  idx   <= idx + 1'b1;
                  maddr <= maddr + 1'b1;
               end
            end
            ENG_WAIT: if (mem_rvalid) begin
               if (mem_rdata != eng_data) pass_q <= 1'b0;
               if (at_last) st <= ENG_IDLE;
               else begin
                  st    <= ENG_ISSUE;
                  cnt   <= cnt + 1'b1;
                  idx   <= idx + 1'b1;
                  maddr <= maddr + 1'b1;
               end
            end
            default: st <= ENG_IDLE;
         endcase
      end
   end

   assign eng_idx   = idx;
   assign mem_req   = (st == ENG_ISSUE);
   assign mem_we    = !rd_q;
   assign mem_addr  = maddr;
   assign mem_wdata = eng_data;
   assign busy      = (st != ENG_IDLE);
   assign pass      = pass_q;

   // R10
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
   // R3
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_gnt && mem_we && !at_last) |=>
         (mem_req && mem_addr == $past(mem_addr) + AW'(1)));
   // R5
   pass_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pass) |-> $past(mem_rvalid));
   // R6
   pass_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pass) |-> $past(start && clr_cmd));
endmodule

// File: rtl/mt_burst_tester.sv
module mt_burst_tester #(
   parameter int DW        = 32,
   parameter int AW        = 32,
   parameter int BUF_DEPTH = 256,
   parameter int LEN_W     = 8,
   localparam int IW       = $clog2(BUF_DEPTH),
   localparam int HAW      = IW + 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [HAW-1:0] host_addr,
   input  logic           host_wr,
   input  logic           host_rd,
   input  logic [DW-1:0]  host_wdata,
   output logic [DW-1:0]  host_rdata,
   output logic           mem_req,
   output logic           mem_we,
   output logic [AW-1:0]  mem_addr,
   output logic [DW-1:0]  mem_wdata,
   input  logic           mem_gnt,
   input  logic           mem_rvalid,
   input  logic [DW-1:0]  mem_rdata
);
   if (AW > DW) begin : g_aw_chk
      $error("mt_burst_tester: address register must fit a host word");
   end

   logic          busy, pass, start;
   logic [LEN_W-1:0] cmd_len_m1;
   logic [IW-1:0] cmd_idx, buf_idx, eng_idx;
   logic          cmd_rd, cmd_clr, buf_wr, buf_rd;
   logic [AW-1:0] base_addr;
   logic [DW-1:0] buf_rdata, eng_data;

   mt_hostif #(.DW(DW), .AW(AW), .IW(IW), .LW(LEN_W)) u_hostif (
      .clk(clk), .rst_n(rst_n),
      .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .busy(busy), .pass(pass), .start(start),
      .cmd_len_m1(cmd_len_m1), .cmd_idx(cmd_idx), .cmd_rd(cmd_rd),
      .cmd_clr(cmd_clr), .base_addr(base_addr),
      .buf_wr(buf_wr), .buf_rd(buf_rd), .buf_idx(buf_idx),
      .buf_rdata(buf_rdata)
   );

   mt_buffer #(.DW(DW), .DEPTH(BUF_DEPTH)) u_buffer (
      .clk(clk),
      .wr_en(buf_wr), .wr_idx(buf_idx), .wr_data(host_wdata),
      .rd_en(buf_rd), .rd_idx(buf_idx), .rd_data(buf_rdata),
      .eng_idx(eng_idx), .eng_data(eng_data)
   );

   mt_engine #(.DW(DW), .AW(AW), .IW(IW), .LW(LEN_W)) u_engine (
      .clk(clk), .rst_n(rst_n),
      .start(start), .len_m1(cmd_len_m1), .start_idx(cmd_idx),
      .rd_cmd(cmd_rd), .clr_cmd(cmd_clr), .base_addr(base_addr),
      .eng_idx(eng_idx), .eng_data(eng_data),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .busy(busy), .pass(pass)
   );
endmodule

// File: tb/mt_burst_tester_test.sv
module mt_burst_tester_test;
   localparam int DW = 32;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [8:0]    host_addr = '0;
   logic          host_wr = 1'b0, host_rd = 1'b0;
   logic [DW-1:0] host_wdata = '0, host_rdata;
   logic          mem_req, mem_we, mem_gnt, mem_rvalid;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata, mem_rdata;

   always #5 clk = ~clk;

   mt_burst_tester uut (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
      .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata)
   );

   int n_vec = 0, n_bad = 0;

   typedef struct { bit we; logic [AW-1:0] addr; logic [DW-1:0] data; } item_t;
   item_t exq[$];
   logic [DW-1:0] sbuf [256];
   logic [DW-1:0] wmem [1024];
   logic [DW-1:0] smem [1024];
   logic [9:0]    flip_a = '0;
   bit            flip_en = 1'b0;
   bit            exp_pass = 1'b1;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // memory model: grants 3 cycles of 4, read data 2 cycles after grant
   logic [1:0] gcnt;
   logic       p1;
   logic [9:0] a1;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gcnt <= '0; mem_gnt <= 1'b0; p1 <= 1'b0; a1 <= '0;
         mem_rvalid <= 1'b0; mem_rdata <= '0;
      end else begin
         gcnt    <= gcnt + 1'b1;
         mem_gnt <= (gcnt != 2'd2);
         p1      <= mem_req && mem_gnt && !mem_we;
         a1      <= mem_addr[9:0];
         if (mem_req && mem_gnt && mem_we) smem[mem_addr[9:0]] <= mem_wdata;
         mem_rvalid <= p1;
         mem_rdata  <= smem[a1] ^ ((flip_en && a1 == flip_a) ? 32'h0000_0100 : 32'h0);
      end
   end

   // monitor: each handshake pops one expected item (R3, R4, R8)
   always @(negedge clk) begin
      if (rst_n && mem_req && mem_gnt) begin
         if (exq.size() == 0) begin
            chk("R7 unexpected request", mem_addr, 32'hFFFF_FFFF);
         end else begin
            item_t it;
            it = exq.pop_front();
            chk(it.we ? "R3 dir" : "R4 dir", 32'(mem_we), 32'(it.we));
            chk(it.we ? "R3 addr" : "R4 addr", mem_addr, it.addr);
            if (it.we) chk("R3 wdata", mem_wdata, it.data);
         end
      end
   end

   task automatic host_write(logic [8:0] a, logic [31:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic host_read(logic [8:0] a, output logic [31:0] d);
      @(negedge clk);
      host_addr = a; host_rd = 1'b1;
      @(negedge clk);
      host_rd = 1'b0;
      d = host_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] v;
      for (int i = 0; i < 2000; i++) begin
         host_read(9'd0, v);
         if (!v[0]) break;
      end
   endtask

   function automatic logic [31:0] pat(int i);
      logic [7:0] b;
      b = 8'(i);
      return {b, ~b, b ^ 8'h5A, 8'hC3};
   endfunction

   task automatic run_cmd(bit rd, bit clr, bit dual, int start, int len,
                          logic [31:0] base, string ptag, bit poke);
      logic [31:0] v, got;
      int idx;
      if (clr) exp_pass = 1'b1;
      for (int k = 0; k < len; k++) begin
         item_t it;
         idx = (start + k) % 256;
         it.we = !rd; it.addr = base + 32'(k); it.data = rd ? '0 : sbuf[idx];
         exq.push_back(it);
         if (!rd) wmem[it.addr[9:0]] = sbuf[idx];
         else begin
            got = wmem[it.addr[9:0]] ^
                  ((flip_en && it.addr[9:0] == flip_a) ? 32'h0000_0100 : 32'h0);
            if (got != sbuf[idx]) exp_pass = 1'b0;
         end
      end
      host_write(9'd1, base);
      host_write(9'd0, 32'(len - 1) | (32'(start) << 8) | (32'(rd) << 16) |
                       (32'(clr) << 17) | (32'(dual) << 18));
      if (poke) begin
         host_read(9'd0, v);
         chk("R7 busy set", 32'(v[0]), 32'd1);
         // dual read of 4 words while busy: must be ignored
         host_write(9'd0, 32'h0005_0003);
      end
      wait_idle();
      chk("R7 no leftover or extra requests", 32'(exq.size()), 32'd0);
      host_read(9'd0, v);
      chk(ptag, 32'(v[1]), 32'(exp_pass));
      chk("R9 mode flag", 32'(v[18]), 32'(dual));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL R7 watchdog: actual busy expected idle");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1
      host_read(9'd0, v);
      chk("R1 status", v, 32'h0000_0002);
      chk("R1 no request", 32'(mem_req), 32'd0);
      // R2 buffer load and readback
      for (int i = 0; i < 256; i++) begin
         sbuf[i] = pat(i);
         host_write(9'h100 | 9'(i), sbuf[i]);
      end
      host_read(9'h100, v);  chk("R2 buf[0]", v, pat(0));
      host_read(9'h101, v);  chk("R2 buf[1]", v, pat(1));
      host_read(9'h17F, v);  chk("R2 buf[127]", v, pat(127));
      host_read(9'h1FF, v);  chk("R2 buf[255]", v, pat(255));
      host_write(9'd1, 32'h1234_5678);
      host_read(9'd1, v);    chk("R2 addr reg", v, 32'h1234_5678);
      // R3 write burst, R4 read burst with busy poke (R7)
      run_cmd(0, 0, 0, 16, 8, 32'h40, "R5 after write", 0);
      run_cmd(1, 1, 0, 16, 8, 32'h40, "R4 compare pass", 1);
      // R8 wrap of the buffer index
      run_cmd(0, 0, 0, 252, 8, 32'h100, "R8 write wrap", 0);
      run_cmd(1, 1, 0, 252, 8, 32'h100, "R8 read wrap pass", 0);
      // R5 mismatch is sticky
      flip_a = 10'h102; flip_en = 1'b1;
      run_cmd(1, 0, 0, 252, 8, 32'h100, "R5 mismatch clears", 0);
      run_cmd(1, 0, 0, 16, 8, 32'h40, "R5 stays clear", 0);
      // R6 clear then compare in the same command
      run_cmd(1, 1, 0, 252, 8, 32'h100, "R6 clear then mismatch", 0);
      flip_en = 1'b0;
      run_cmd(1, 1, 0, 16, 8, 32'h40, "R6 clear restores", 0);
      // R9 mode flag
      run_cmd(1, 1, 1, 16, 4, 32'h40, "R9 pass", 0);
      run_cmd(1, 0, 0, 16, 1, 32'h40, "R9 single word", 0);
      // longest used burst
      run_cmd(0, 0, 0, 128, 32, 32'h200, "R3 long write", 0);
      run_cmd(1, 1, 0, 128, 32, 32'h200, "R4 long read", 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule